// File: doc/BRIEF.md
# Mixed-Attribute Register Bank

A small register file that sits behind a single-cycle register port (select, write enable, byte address, write data, read data). There are four word registers, and each one follows a different access rule. The control word is plain read/write and is also driven out to the hardware side. The hardware status word is read-only and mirrors a hardware input. The event flag word has its bits set by hardware pulses and cleared by software writing ones. The receive word is loaded by a hardware strobe and empties itself when software reads it.

Read data is combinational from the current register state, so it is valid in the same cycle as the access. Any side effect of that access (a write, a write-one clear, or a clear caused by the read) takes effect at the next rising clock edge. An interrupt output goes high whenever any event flag bit is set.

Top module: `attr_regbank`

## Requirements
- R1: After a synchronous active-low reset, the control, event flag and receive registers all read as zero.
- R2: The control register at offset 0x0 reads back the last value written to it, and its contents always appear on `ctrl_q`.
- R3: The status word at offset 0x4 reads back the current value of `hw_status`. Writes to offset 0x4 change no register.
- R4: A write to the event flag register at offset 0x8 clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: A pulse on bit n of `evt_set` sets flag bit n on the next edge. If that edge also carries a write-one clear of the same bit, the set wins.
- R6: The receive register at offset 0xC loads `rx_in` on an edge where `rx_load` is high. A read returns the current value, and the register is zero after that edge, so an immediate second read returns zero.
- R7: If `rx_load` is high in the same cycle as a read of offset 0xC, the newly loaded value is kept and the clear does not happen.
- R8: Reads of unmapped offsets return zero, and writes to them change no register.
- R9: `irq` is high exactly when at least one event flag bit is set.
- R10: A write never clears the receive register, and a bus access with `sel` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register port select |
| wr | input | 1 | 1 = write, 0 = read (when selected) |
| addr | input | AW | Byte address; bits [3:2] pick a word |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data (combinational) |
| hw_status | input | DW | Hardware status value |
| evt_set | input | DW | Event pulses, one per flag bit |
| rx_load | input | 1 | Receive data strobe |
| rx_in | input | DW | Receive data value |
| ctrl_q | output | DW | Control register contents |
| irq_q | output | DW | Event flag contents |
| irq | output | 1 | OR of all event flags |

## Verification
The checker assumes a read counts as exactly one access for every cycle that `sel` is high with `wr` low. A read that is held for several cycles therefore clears the receive register after its first cycle. The checker also assumes the inputs settle well before each edge. The bench changes inputs only on the falling edge and holds `sel` high for one cycle per access. It drives the hardware-side inputs at the same time as the bus access only in the scenarios that test collisions.

// File: rtl/attr_regbank.sv
module attr_regbank #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] hw_status,
  input  logic [DW-1:0] evt_set,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_in,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] irq_q,
  output logic          irq
);
  localparam logic [1:0] W_CTRL = 2'd0, W_STAT = 2'd1, W_FLAG = 2'd2, W_RX = 2'd3;

  logic [DW-1:0] ctrl_r, flag_r, rx_r;
  logic          mapped;
  logic [1:0]    widx;

  assign widx   = addr[3:2];
  assign mapped = (addr[1:0] == 2'b00) && (addr[AW-1:4] == '0);

  logic hit_ctrl_w, hit_flag_w, hit_rx_r;
  assign hit_ctrl_w = sel && wr && mapped && widx == W_CTRL;
  assign hit_flag_w = sel && wr && mapped && widx == W_FLAG;
  assign hit_rx_r   = sel && !wr && mapped && widx == W_RX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      flag_r <= '0;
      rx_r   <= '0;
    end else begin
      if (hit_ctrl_w) ctrl_r <= wdata;
      flag_r <= (flag_r & ~(hit_flag_w ? wdata : '0)) | evt_set;
      if (rx_load)       rx_r <= rx_in;
      else if (hit_rx_r) rx_r <= '0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr && mapped) begin
      case (widx)
        W_CTRL:  rdata = ctrl_r;
        W_STAT:  rdata = hw_status;
        W_FLAG:  rdata = flag_r;
        default: rdata = rx_r;
      endcase
    end
  end

  assign ctrl_q = ctrl_r;
  assign irq_q  = flag_r;
  assign irq    = |flag_r;
endmodule

// File: rtl/attr_regbank_chk.sv
module attr_regbank_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] hw_status,
  input logic [DW-1:0] evt_set,
  input logic          rx_load,
  input logic [DW-1:0] rx_in,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] irq_q,
  input logic          irq
);
  logic rd_rx, wr_ctl, wr_flag, rd_stat, wr_any;
  assign rd_rx   = sel && !wr && addr == AW'(12);
  assign rd_stat = sel && !wr && addr == AW'(4);
  assign wr_ctl  = sel && wr && addr == AW'(0);
  assign wr_flag = sel && wr && addr == AW'(8);
  assign wr_any  = sel && wr;

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctrl_q));
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> ctrl_q == $past(wdata));
  assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> rdata == hw_status);
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> ((irq_q & $past(wdata) & ~$past(evt_set)) == '0));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_q & $past(evt_set)) == $past(evt_set)));
  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_load) |=> rdata == '0 || !rd_rx);
  assert_rx_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> !rd_rx || rdata == $past(rx_in));
  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_q != '0));
  assert_no_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> rdata == '0);
  assert_ctrl_on_other_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !wr_ctl) |=> $stable(ctrl_q));
endmodule

bind attr_regbank attr_regbank_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_attr_regbank.sv
`timescale 1ns/1ps
module tb_attr_regbank;
  localparam int DW = 32, AW = 8;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0, rx_load = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, hw_status = '0, evt_set = '0, rx_in = '0;
  logic [DW-1:0] rdata, ctrl_q, irq_q;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  attr_regbank #(.DW(DW), .AW(AW)) dut (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sel = 0; wr = 0; evt_set = '0; rx_load = 0;
  endtask

  task automatic bwrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bread(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    bread(8'h0, v); chk("R1 ctrl", v, '0);
    bread(8'h8, v); chk("R1 flags", v, '0);
    bread(8'hC, v); chk("R1 rx", v, '0);
    chk("R9 irq at reset", {31'b0, irq}, '0);
  endtask

  task automatic t_ctrl();
    logic [DW-1:0] v;
    bwrite(8'h0, 32'hA5A5_1234);
    bread(8'h0, v); chk("R2 readback", v, 32'hA5A5_1234);
    chk("R2 ctrl_q", ctrl_q, 32'hA5A5_1234);
    bwrite(8'h0, 32'h0F0F_0000);
    bread(8'h0, v); chk("R2 second value", v, 32'h0F0F_0000);
  endtask

  task automatic t_status();
    logic [DW-1:0] v;
    hw_status = 32'hDEAD_BEEF;
    bread(8'h4, v); chk("R3 status", v, 32'hDEAD_BEEF);
    bwrite(8'h4, 32'h1111_1111);
    bread(8'h4, v); chk("R3 write ignored", v, 32'hDEAD_BEEF);
    bread(8'h0, v); chk("R3 ctrl untouched", v, 32'h0F0F_0000);
    hw_status = 32'h0000_0042;
    bread(8'h4, v); chk("R3 follows hw", v, 32'h42);
  endtask

  task automatic t_flags();
    logic [DW-1:0] v;
    @(negedge clk); evt_set = 32'h0000_00F3;
    idle();
    chk("R9 irq high", {31'b0, irq}, 32'd1);
    bread(8'h8, v); chk("R5 set by pulse", v, 32'hF3);
    bwrite(8'h8, 32'h0000_0021);
    bread(8'h8, v); chk("R4 w1c partial", v, 32'hD2);
    // collision: set bit 1 while clearing bits 1 and 4
    @(negedge clk); sel = 1; wr = 1; addr = 8'h8; wdata = 32'h12; evt_set = 32'h2;
    idle();
    bread(8'h8, v); chk("R5 set wins", v, 32'hC2);
    bwrite(8'h8, 32'hFFFF_FFFF);
    bread(8'h8, v); chk("R4 clear all", v, '0);
    chk("R9 irq low", {31'b0, irq}, '0);
  endtask

  task automatic t_rx();
    logic [DW-1:0] v;
    @(negedge clk); rx_load = 1; rx_in = 32'h0000_ABCD;
    idle();
    bwrite(8'hC, 32'hFFFF_FFFF);
    bread(8'hC, v); chk("R10 write no clear / R6 load", v, 32'hABCD);
    bread(8'hC, v); chk("R6 second read zero", v, '0);
    @(negedge clk); rx_load = 1; rx_in = 32'h55;
    idle();
    @(negedge clk); sel = 1; wr = 0; addr = 8'hC; rx_load = 1; rx_in = 32'h77;
    #1 v = rdata; chk("R7 read old value", v, 32'h55);
    idle();
    bread(8'hC, v); chk("R7 load kept", v, 32'h77);
    bread(8'hC, v); chk("R6 cleared", v, '0);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    bwrite(8'h10, 32'h1234_5678);
    bwrite(8'h2, 32'h1234_5678);
    bread(8'h10, v); chk("R8 unmapped read", v, '0);
    bread(8'h0, v); chk("R8 ctrl untouched", v, 32'h0F0F_0000);
    @(negedge clk); rx_load = 1; rx_in = 32'h99;
    idle();
    @(negedge clk); sel = 0; wr = 1; addr = 8'h0; wdata = 32'hFFFF;
    #1 chk("R10 no sel rdata", rdata, '0);
    idle();
    chk("R10 no sel ctrl", ctrl_q, 32'h0F0F_0000);
    bread(8'hC, v); chk("R10 rx kept", v, 32'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_status();
    t_flags();
    t_rx();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule